// File: doc/BRIEF.md
# Serial Lamp Segment Pattern Controller

This block drives a chain of external lamp-segment drivers. Each driver stage holds one bit, and the chain takes a four-wire serial link: clock, data, latch and output enable. On a start request the block samples a copy reduction ratio, given in whole percent. It turns that ratio into a count of lit segments at each edge of the chain. It then builds the on/off pattern, shifts it out bit by bit, pulses the latch, and finally switches the drivers on.

The serial clock comes from the system clock through a half-period count given at a port. Data changes only together with a rising serial clock, so the chain can sample it on the falling edge. The enable line stays low from the moment a transfer is accepted until the new pattern has been latched, so the lamps never show a half-shifted pattern. A busy flag tells the host when the next request may be issued.

Top module: `lamp_pattern_ctrl`

## Requirements
- R1: While reset is asserted and right after it, busy, serClk, serData, serLatch and serEnable are all low.
- R2: The ratio is grouped into bands, each with a lit count per side. 96 to 100 gives 1. 64 to 95 gives 2 + (95 - ratio)/4 (integer division), which is 2 for 92..95 and 9 for 64..67. 59 to 63 gives 10. 56 to 58 gives 11. 52 to 55 gives 12. 50 to 51 gives 13.
- R3: A ratio above 100 is treated as 100, and a ratio below 50 is treated as 50.
- R4: Bit i of the pattern (i from 0 to SEG_COUNT-1) is 1, meaning lit, when i < lit or i >= SEG_COUNT - lit. Bit SEG_COUNT-1 is sent first and bit 0 last.
- R5: serClk idles low. A transfer makes exactly SEG_COUNT serClk pulses, and serData changes only in the cycle where serClk rises.
- R6: Let d be divHalf, with 0 treated as 1. Each serClk high phase and each low phase lasts d system cycles. Busy stays high for exactly 2*d*SEG_COUNT + 3*d cycles.
- R7: After the last bit, serLatch gives exactly one high pulse of d cycles, with serClk low, starting d cycles after the last falling edge of serClk.
- R8: serEnable drops when a start is accepted and stays low while busy is high. It rises d cycles after serLatch falls, on the same edge where busy falls.
- R9: A start seen while idle raises busy on the next cycle, and the ratio is captured on that same edge.
- R10: A start seen while busy is ignored: the pattern shifted out and the timing of the transfer in progress do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to load and send a new pattern |
| ratioPct | input | 8 | Reduction ratio in percent |
| divHalf | input | DIV_W | System cycles per serial clock half-period (0 acts as 1) |
| busy | output | 1 | Transfer in progress |
| serClk | output | 1 | Serial shift clock to the driver chain |
| serData | output | 1 | Serial pattern bit |
| serLatch | output | 1 | Transfers the shifted pattern to the driver outputs |
| serEnable | output | 1 | Driver output enable, high turns lamps on |

## Verification
Two events can fall in the same cycle: a new start request and the shifting of a transfer already in progress. The bench raises start with a different ratio for several cycles in the middle of a shift. It then checks that the captured bit stream, the latch count and the busy length all still match the first request, and that a later request is accepted normally. A second coincidence is the enable rising on the same edge that busy falls. The checker confirms this on every transfer, and the bench also confirms that enable is never high during any sampled busy cycle.

// File: rtl/lamp_pkg.sv
package lamp_pkg;
  typedef struct packed {
    logic load;   // capture ratio and build pattern
    logic drive;  // present next bit on serData
  } lampStrobe_t;
endpackage

// File: rtl/lamp_datapath.sv
module lamp_datapath
  import lamp_pkg::*;
#(
  parameter int SEG_COUNT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  lampStrobe_t stb,
  input  logic [7:0]  ratioPct,
  output logic        serData
);
  logic [SEG_COUNT-1:0] patNext;
  logic [SEG_COUNT-1:0] shiftReg;
  int clampedPct;
  int litCount;

  always_comb begin
    if (int'(ratioPct) > 100)     clampedPct = 100;
    else if (int'(ratioPct) < 50) clampedPct = 50;
    else                          clampedPct = int'(ratioPct);
  end

  always_comb begin
    if (clampedPct >= 96)      litCount = 1;
    else if (clampedPct >= 64) litCount = 2 + (95 - clampedPct) / 4;
    else if (clampedPct >= 59) litCount = 10;
    else if (clampedPct >= 56) litCount = 11;
    else if (clampedPct >= 52) litCount = 12;
    else                       litCount = 13;
  end

  always_comb begin
    for (int i = 0; i < SEG_COUNT; i++)
      patNext[i] = (i < litCount) || (i >= SEG_COUNT - litCount);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      serData  <= 1'b0;
    end else if (stb.load) begin
      shiftReg <= patNext;
    end else if (stb.drive) begin
      serData  <= shiftReg[SEG_COUNT-1];
      shiftReg <= {shiftReg[SEG_COUNT-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/lamp_control.sv
module lamp_control
  import lamp_pkg::*;
#(
  parameter int SEG_COUNT = 64,
  parameter int DIV_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] divHalf,
  output lampStrobe_t      stb,
  output logic             busy,
  output logic             serClk,
  output logic             serLatch,
  output logic             serEnable
);
  localparam int BIT_W = $clog2(SEG_COUNT + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SEG_COUNT);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_LATCH, ST_SETTLE} ctrlState_t;
  ctrlState_t state;

  logic [DIV_W-1:0] phaseCnt;
  logic [DIV_W-1:0] halfLen;
  logic [BIT_W-1:0] bitCnt;
  logic             tick;

  assign halfLen = (divHalf == '0) ? DIV_W'(1) : divHalf;
  assign tick    = (phaseCnt == halfLen - DIV_W'(1));
  assign busy    = (state != ST_IDLE);

  always_comb begin
    stb.load  = (state == ST_IDLE) && start;
    stb.drive = (state == ST_SHIFT) && tick && !serClk && (bitCnt != LAST_BIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phaseCnt  <= '0;
      bitCnt    <= '0;
      serClk    <= 1'b0;
      serLatch  <= 1'b0;
      serEnable <= 1'b0;
    end else begin
      if (state != ST_IDLE) phaseCnt <= tick ? '0 : phaseCnt + DIV_W'(1);
      case (state)
        ST_IDLE: if (start) begin
          state     <= ST_SHIFT;
          phaseCnt  <= '0;
          bitCnt    <= '0;
          serEnable <= 1'b0;
        end
        ST_SHIFT: if (tick) begin
          if (!serClk) begin
            if (bitCnt == LAST_BIT) begin
              serLatch <= 1'b1;
              state    <= ST_LATCH;
            end else begin
              serClk <= 1'b1;
            end
          end else begin
            serClk <= 1'b0;
            bitCnt <= bitCnt + BIT_W'(1);
          end
        end
        ST_LATCH: if (tick) begin
          serLatch <= 1'b0;
          state    <= ST_SETTLE;
        end
        ST_SETTLE: if (tick) begin
          serEnable <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lamp_pattern_ctrl.sv
module lamp_pattern_ctrl
  import lamp_pkg::*;
#(
  parameter int SEG_COUNT = 64,
  parameter int DIV_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       ratioPct,
  input  logic [DIV_W-1:0] divHalf,
  output logic             busy,
  output logic             serClk,
  output logic             serData,
  output logic             serLatch,
  output logic             serEnable
);
  lampStrobe_t stb;

  lamp_control #(.SEG_COUNT(SEG_COUNT), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .divHalf(divHalf), .stb(stb),
    .busy(busy), .serClk(serClk), .serLatch(serLatch), .serEnable(serEnable)
  );

  lamp_datapath #(.SEG_COUNT(SEG_COUNT)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .ratioPct(ratioPct), .serData(serData)
  );
endmodule

// File: rtl/lamp_ctrl_checker.sv
module lamp_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic serClk,
  input logic serData,
  input logic serLatch,
  input logic serEnable
);
  a_r5_data_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(serData) |-> $rose(serClk));
  a_r7_latch_with_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    serLatch |-> !serClk);
  a_r8_enable_off_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !serEnable);
  a_r8_enable_rise_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serEnable) |-> $fell(busy));
  a_r9_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r5_clock_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!serClk && !serLatch));
endmodule

bind lamp_pattern_ctrl lamp_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .serClk(serClk),
  .serData(serData), .serLatch(serLatch), .serEnable(serEnable)
);

// File: tb/sim_lamp_pattern_ctrl.sv
`timescale 1ns/1ps
module sim_lamp_pattern_ctrl;
  localparam int SEG = 64;
  localparam int DW  = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] ratioPct = 8'd100;
  logic [DW-1:0] divHalf = 4'd2;
  logic busy, serClk, serData, serLatch, serEnable;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lamp_pattern_ctrl #(.SEG_COUNT(SEG), .DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ratioPct(ratioPct), .divHalf(divHalf),
    .busy(busy), .serClk(serClk), .serData(serData), .serLatch(serLatch), .serEnable(serEnable)
  );

  // monitors
  logic [SEG-1:0] capBits;
  int fallCnt, latchCnt, busyCyc, enBusyErr;
  always @(negedge serClk) if (rst_n) begin
    capBits <= {capBits[SEG-2:0], serData};
    fallCnt <= fallCnt + 1;
  end
  always @(posedge serLatch) if (rst_n) latchCnt <= latchCnt + 1;
  always @(negedge clk) if (rst_n) begin
    if (busy) busyCyc <= busyCyc + 1;
    if (busy && serEnable) enBusyErr <= enBusyErr + 1;
  end

  // ratio, expected lit per side
  localparam logic [15:0] VEC [0:17] = '{
    {8'd100, 8'd1}, {8'd96, 8'd1},  {8'd95, 8'd2},  {8'd92, 8'd2},
    {8'd91, 8'd3},  {8'd87, 8'd4},  {8'd84, 8'd4},  {8'd83, 8'd5},
    {8'd67, 8'd9},  {8'd64, 8'd9},  {8'd63, 8'd10}, {8'd59, 8'd10},
    {8'd58, 8'd11}, {8'd55, 8'd12}, {8'd52, 8'd12}, {8'd51, 8'd13},
    {8'd50, 8'd13}, {8'd75, 8'd7}
  };

  function automatic logic [SEG-1:0] expPat(int lit);
    logic [SEG-1:0] p;
    for (int i = 0; i < SEG; i++) p[i] = (i < lit) || (i >= SEG - lit);
    return p;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    fallCnt = 0; latchCnt = 0; busyCyc = 0; enBusyErr = 0; capBits = '0;
  endtask

  task automatic runXfer(input logic [7:0] r, input int lit, input int d, input string req);
    int dd;
    dd = (d == 0) ? 1 : d;
    clearMon();
    divHalf = DW'(d);
    ratioPct = r;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(busy === 1'b1, "R9", "busy after start", busy, 1);
    while (busy) @(negedge clk);
    check(capBits === expPat(lit), req, "pattern", capBits, expPat(lit));
    check(fallCnt == SEG, "R5", "clock pulses", fallCnt, SEG);
    check(latchCnt == 1, "R7", "latch pulses", latchCnt, 1);
    check(busyCyc == 2*dd*SEG + 3*dd, "R6", "busy length", busyCyc, 2*dd*SEG + 3*dd);
    check(enBusyErr == 0 && serEnable === 1'b1, "R8", "enable sequencing", serEnable, 1);
  endtask

  initial begin
    #1;
    check(busy === 0 && serClk === 0 && serData === 0 && serLatch === 0 && serEnable === 0,
          "R1", "outputs in reset", {busy, serClk, serData, serLatch, serEnable}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy === 0 && serClk === 0 && serLatch === 0 && serEnable === 0,
          "R1", "outputs after reset", {busy, serClk, serLatch, serEnable}, 0);

    // R2 / R4 table walk
    for (int k = 0; k < 18; k++)
      runXfer(VEC[k][15:8], int'(VEC[k][7:0]), 2, "R2/R4");

    // R3 clamping
    runXfer(8'd120, 1, 2, "R3");
    runXfer(8'd255, 1, 2, "R3");
    runXfer(8'd30, 13, 2, "R3");
    runXfer(8'd0, 13, 2, "R3");

    // R6 divider variants (0 acts as 1)
    runXfer(8'd80, 5, 0, "R6");
    runXfer(8'd80, 5, 1, "R6");
    runXfer(8'd70, 8, 5, "R6");

    // R10 start during shift ignored
    clearMon();
    divHalf = 4'd2; ratioPct = 8'd100;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    ratioPct = 8'd50; start = 1;
    repeat (6) @(negedge clk);
    start = 0;
    while (busy) @(negedge clk);
    check(capBits === expPat(1), "R10", "pattern kept", capBits, expPat(1));
    check(busyCyc == 4*SEG + 6, "R10", "busy length kept", busyCyc, 4*SEG + 6);
    check(latchCnt == 1, "R10", "single latch", latchCnt, 1);
    runXfer(8'd50, 13, 2, "R10");

    // R8 enable drops on accepted start
    divHalf = 4'd2;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(serEnable === 1'b0, "R8", "enable off at start", serEnable, 0);
    while (busy) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule